// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This block gathers the event pulses of three timers (compare matches, overflows and one input capture) into an eight-bit pending-flag register. It also holds an eight-bit enable register of the same shape. The CPU reaches both registers through a small I/O port with a combinational read path. Software clears a pending flag by writing a one to its bit position. Hardware clears it when the CPU acknowledges that source's interrupt vector.

A source may request service only when three conditions hold together: the global interrupt enable input, the source's enable bit and its pending flag. The unit arbitrates among the qualified sources and holds the winner. It then presents a request together with a fixed vector address. That vector stays put until the CPU acknowledges it, or until the held source stops qualifying. After an acknowledge, the request drops for one cycle, and then the next qualified source is presented.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_req` is low.
- R2: An event pulse on `evt_i[k]` sets flag bit k at the next clock edge. The flag bits are: bit 7 timer2 compare, bit 6 timer2 overflow, bit 5 timer1 capture, bit 4 timer1 compare-A, bit 3 timer1 compare-B, bit 2 timer1 overflow, bit 0 timer0 overflow. The flag register reads at I/O address 0x38.
- R3: A write to 0x38 clears every flag bit written with one. Bits written with zero keep their value.
- R4: When a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R5: The enable register is plain read/write at I/O address 0x39, with the same bit layout as the flags. Bit 1 reads zero in both registers, whatever is written or pulsed.
- R6: `irq_req` is high only while `global_ie`, an enable bit and its flag are all one. It rises one cycle after those three conditions first hold together. It falls in the same cycle that any of them is removed from the held source.
- R7: The vectors are: timer2 compare 0x3, timer2 overflow 0x4, timer1 capture 0x5, compare-A 0x6, compare-B 0x7, timer1 overflow 0x8, timer0 overflow 0x9.
- R8: When several qualified flags are pending, the one with the lowest vector is presented first.
- R9: While `irq_req` is high and not acknowledged, `irq_vec` does not change. This holds even if a higher-priority flag arrives in the meantime.
- R10: `irq_ack` while `irq_req` is high clears only the presented source's flag. `irq_req` then drops for one cycle, and the next qualified source is presented in the cycle after.
- R11: A flag set while its enable bit is zero stays pending. It requests one cycle after the enable bit is written to one.
- R12: Writes to any other I/O address change neither register, and reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Timer event pulses, one per flag bit position |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| global_ie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 4 | Vector address of the presented source |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |

## Verification
Each source is first driven alone, to tell the vector table and the clear-on-acknowledge path apart for every bit position. All sources are then pulsed at once and drained one acknowledge at a time, which shows the priority order. A higher-priority pulse that lands while a lower one is held shows whether the presented vector is stable. The gating tests drop the global enable and the per-source enable one at a time. The collision tests land a set event on the same cycle as a write-one clear or an acknowledge, which separates set-wins from clear-wins.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NSRC  = 8;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 4;
  localparam int RSV_BIT = 1;
  localparam logic [NSRC-1:0] IMPL_MASK = ~(NSRC'(1) << RSV_BIT);

  // Fixed vector per flag position; bit 7 has the lowest vector.
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] v;
    case (idx)
      3'd7:    v = 4'h3;
      3'd6:    v = 4'h4;
      3'd5:    v = 4'h5;
      3'd4:    v = 4'h6;
      3'd3:    v = 4'h7;
      3'd2:    v = 4'h8;
      3'd0:    v = 4'h9;
      default: v = 4'h0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] wclr_i,
  input  logic [NSRC-1:0] hclr_i,
  output logic [NSRC-1:0] flags_o
);
  logic [NSRC-1:0] flags_q, flags_d;
  logic            upd_en;

  always_comb begin
    // set has priority over both clear paths
    flags_d = ((flags_q & ~wclr_i & ~hclr_i) | set_i) & IMPL_MASK;
    upd_en  = |{set_i, wclr_i, hclr_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/tmr_irq_mask.sv
module tmr_irq_mask
  import tmr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_q, mask_d;

  always_comb mask_d = wdata_i & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
  import tmr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  qual_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NSRC-1:0]  clr_o
);
  logic             held_q, held_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic             live, accept, upd_en;

  // Highest bit position wins (lowest vector); scan upward, last hit kept.
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual_i[i]) begin
        win_any = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    live   = held_q && qual_i[idx_q];
    accept = ack_i && live;
    held_d = held_q;
    idx_d  = idx_q;
    if (accept || (held_q && !qual_i[idx_q])) begin
      held_d = 1'b0;
    end else if (!held_q && win_any) begin
      held_d = 1'b1;
      idx_d  = win_idx;
    end
    upd_en = (held_d != held_q) || (idx_d != idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      idx_q  <= '0;
    end else if (upd_en) begin
      held_q <= held_d;
      idx_q  <= idx_d;
    end
  end

  assign req_o = live;
  assign vec_o = vec_of(idx_q);
  assign clr_o = accept ? (NSRC'(1) << idx_q) : '0;
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
#(
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h38,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [NSRC-1:0]   io_wdata,
  output logic [NSRC-1:0]   io_rdata,
  input  logic              global_ie,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack
);
  logic            rst_m, rst_s;
  logic            sel_flag, sel_mask;
  logic [NSRC-1:0] wclr, hclr, flags, mask, qual;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  always_comb begin
    sel_flag = (io_addr == FLAG_ADDR);
    sel_mask = (io_addr == MASK_ADDR);
    wclr     = (io_wr && sel_flag) ? io_wdata : '0;
    qual     = flags & mask & {NSRC{global_ie}};
    if (sel_flag)      io_rdata = flags;
    else if (sel_mask) io_rdata = mask;
    else               io_rdata = '0;
  end

  tmr_irq_flags i_flags (
    .clk    (clk),
    .rst_n  (rst_s),
    .set_i  (evt_i & IMPL_MASK),
    .wclr_i (wclr),
    .hclr_i (hclr),
    .flags_o(flags)
  );

  tmr_irq_mask i_mask (
    .clk    (clk),
    .rst_n  (rst_s),
    .wr_en_i(io_wr && sel_mask),
    .wdata_i(io_wdata),
    .mask_o (mask)
  );

  tmr_irq_arb i_arb (
    .clk   (clk),
    .rst_n (rst_s),
    .qual_i(qual),
    .ack_i (irq_ack),
    .req_o (irq_req),
    .vec_o (irq_vec),
    .clr_o (hclr)
  );
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk
  import tmr_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_s,
  input logic [NSRC-1:0]  evt_i,
  input logic [NSRC-1:0]  flags,
  input logic [NSRC-1:0]  mask,
  input logic [NSRC-1:0]  hclr,
  input logic [NSRC-1:0]  io_rdata,
  input logic             global_ie,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_ack
);
  for (genvar k = 0; k < NSRC; k++) begin : g_set
    if (k != RSV_BIT) begin : g_impl
      assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_s)
        evt_i[k] |=> flags[k]);
    end
  end

  assert_rsv_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !io_rdata[RSV_BIT] && !flags[RSV_BIT] && !mask[RSV_BIT]);

  assert_req_needs_gie_R6: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> global_ie);

  assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> (irq_vec >= 4'h3 && irq_vec <= 4'h9));

  assert_vec_stable_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_req && !irq_ack) |=> (!irq_req || $stable(irq_vec)));

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (|hclr) |=> ((flags & $past(hclr) & ~$past(evt_i)) == '0));

  assert_ack_drops_req_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (|hclr) |=> !irq_req);
endmodule

bind tmr_irq_unit tmr_irq_chk i_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .evt_i    (evt_i),
  .flags    (flags),
  .mask     (mask),
  .hclr     (hclr),
  .io_rdata (io_rdata),
  .global_ie(global_ie),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .irq_ack  (irq_ack)
);

// File: tb/test_tmr_irq_unit.sv
module test_tmr_irq_unit;
  localparam logic [5:0] FA = 6'h38;
  localparam logic [5:0] MA = 6'h39;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic [5:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       global_ie = 1'b0;
  logic       irq_req;
  logic [3:0] irq_vec;
  logic       irq_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_unit i_tmr_irq_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .global_ie(global_ie),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  function automatic int exp_vec(input int bitpos);
    case (bitpos)
      7: return 3; 6: return 4; 5: return 5; 4: return 6;
      3: return 7; 2: return 8; 0: return 9;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    step(1);
    io_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    evt_i = m;
    step(1);
    evt_i = '0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
  endtask

  task automatic clean();
    global_ie = 1'b0;
    wr(MA, 8'h00);
    wr(FA, 8'hFF);
    step(1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(FA, d); chk("R1 flags", d, 0);
    rd(MA, d); chk("R1 mask", d, 0);
    chk("R1 req", irq_req, 0);
  endtask

  task automatic t_set_flags();
    logic [7:0] d;
    clean();
    pulse(8'h81); rd(FA, d); chk("R2 bits 7,0", d, 8'h81);
    pulse(8'h3C); rd(FA, d); chk("R2 accumulate", d, 8'hBD);
    pulse(8'h02); rd(FA, d); chk("R5 reserved flag", d, 8'hBD);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(FA, 8'h05); rd(FA, d); chk("R3 clear ones", d, 8'hB8);
    wr(FA, 8'h00); rd(FA, d); chk("R3 zero keeps", d, 8'hB8);
  endtask

  task automatic t_conflict();
    logic [7:0] d;
    clean();
    evt_i = 8'h10; io_addr = FA; io_wdata = 8'h10; io_wr = 1'b1;
    step(1);
    evt_i = '0; io_wr = 1'b0;
    rd(FA, d); chk("R4 set beats write clear", d, 8'h10);
    wr(FA, 8'hFF);
    wr(MA, 8'h01); global_ie = 1'b1;
    pulse(8'h01); step(1);
    chk("R4 req before ack", irq_req, 1);
    evt_i = 8'h01; irq_ack = 1'b1;
    step(1);
    evt_i = '0; irq_ack = 1'b0;
    rd(FA, d); chk("R4 set beats ack clear", d, 8'h01);
  endtask

  task automatic t_mask_rw();
    logic [7:0] d;
    clean();
    wr(MA, 8'hFF); rd(MA, d); chk("R5 mask rw", d, 8'hFD);
    wr(MA, 8'h5A); rd(MA, d); chk("R5 mask pattern", d, 8'h58);
  endtask

  task automatic t_gating();
    clean();
    wr(MA, 8'h04); pulse(8'h04); step(2);
    chk("R6 no gie", irq_req, 0);
    global_ie = 1'b1; #1;
    chk("R6 latency zero", irq_req, 0);
    step(1);
    chk("R6 req with all three", irq_req, 1);
    global_ie = 1'b0; #1;
    chk("R6 gie drop", irq_req, 0);
    global_ie = 1'b1; step(2);
    chk("R6 req again", irq_req, 1);
    wr(MA, 8'h00);
    chk("R6 enable drop", irq_req, 0);
  endtask

  task automatic t_vectors();
    logic [7:0] d;
    for (int b = 0; b < 8; b++) begin
      if (b == 1) continue;
      clean();
      wr(MA, 8'(1 << b)); global_ie = 1'b1;
      pulse(8'(1 << b)); step(1);
      chk("R7 req", irq_req, 1);
      chk("R7 vector", irq_vec, exp_vec(b));
      ack();
      chk("R10 req drops after ack", irq_req, 0);
      rd(FA, d); chk("R10 flag cleared", d, 0);
    end
  endtask

  task automatic t_priority();
    int order [7] = '{3, 4, 5, 6, 7, 8, 9};
    logic [7:0] d;
    clean();
    wr(MA, 8'hFF); global_ie = 1'b1;
    pulse(8'hFD); step(1);
    for (int i = 0; i < 7; i++) begin
      chk("R8 order", irq_vec, order[i]);
      chk("R8 req", irq_req, 1);
      ack();
      chk("R10 one-cycle gap", irq_req, 0);
      step(1);
    end
    rd(FA, d); chk("R10 all drained", d, 0);
  endtask

  task automatic t_stable();
    logic [7:0] d;
    clean();
    wr(MA, 8'hFF); global_ie = 1'b1;
    pulse(8'h01); step(1);
    chk("R9 held vec", irq_vec, 9);
    pulse(8'h80); step(2);
    chk("R9 vec stable", irq_vec, 9);
    chk("R9 req still", irq_req, 1);
    ack();
    rd(FA, d); chk("R10 only presented cleared", d, 8'h80);
    step(1);
    chk("R10 next presented", irq_vec, 3);
  endtask

  task automatic t_pending();
    clean();
    global_ie = 1'b1;
    pulse(8'h20); step(3);
    chk("R11 masked pending", irq_req, 0);
    wr(MA, 8'h20);
    chk("R11 not yet", irq_req, 0);
    step(1);
    chk("R11 req after enable", irq_req, 1);
    chk("R11 vec", irq_vec, 5);
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    clean();
    wr(6'h3A, 8'hFF);
    rd(6'h3A, d); chk("R12 other reads zero", d, 0);
    rd(FA, d); chk("R12 flags untouched", d, 0);
    rd(MA, d); chk("R12 mask untouched", d, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_set_flags();
    t_w1c();
    t_conflict();
    t_mask_rw();
    t_gating();
    t_vectors();
    t_priority();
    t_stable();
    t_pending();
    t_other_addr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule